// File: doc/BRIEF.md
# Low-Power Clock Mode Sequencer

This block decides which clock mode a small microcontroller core runs in. There are three modes. In active mode the main oscillator runs. In subactive mode the core runs from the slow sub-clock and the main oscillator is off. In watch mode only the time base keeps running. A fourth, transient state covers the oscillator settling interval on the way back to active mode. The whole block runs on the sub-clock, and one `clk` cycle is one sub-clock cycle.

The core gives the block a one-cycle stop/standby strobe and two mode flags: low-speed-on and direct-transfer-on. A two-bit frame select picks the period of an internal interrupt-frame strobe. There are six raw wake sources: one external interrupt, one timer overflow and four wake-up pins. In watch and subactive modes the block does not pass these requests on when they arrive. It collects them and releases them only on the frame strobe. When a wake sends the block back to active mode, the main oscillator is enabled and a settling count runs before the core sees the interrupt. External and pin requests can also be delayed by a further whole frame, depending on the frame select.

The block also holds the two-speed instruction-rate select bit. That bit can be written only while the block is in active mode.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after release, the block is in active mode and the main-oscillator enable is high. All interrupt outputs are low and the rate bit is 0. Mode codes on `mode` are: 0 active, 1 subactive, 2 watch, 3 waking (settling).
- R2: In active mode, a request on any wake source gives a one-cycle pulse on the matching interrupt output in the next cycle. The request bit order is bit 0 timer, bit 1 external, bits 2 to 5 wake pins 0 to 3.
- R3: In active mode, a stop strobe moves the block to watch mode in the next cycle, and the oscillator enable goes low.
- R4: In watch and subactive modes, requests are collected and no interrupt output rises, except in the cycle after a frame-strobe cycle. In subactive mode, every collected request is issued in that cycle.
- R5: The frame strobe is high for one cycle per frame. The frame period is 2^FRAME_LOG2_A cycles when the select is 00 or 11, and 2^FRAME_LOG2_B cycles when it is 01 or 10.
- R6: In watch mode with low-speed-on at 1, a frame strobe with any request collected moves the block to subactive mode in the next cycle. The collected requests are issued as interrupts in that same cycle.
- R7: In watch mode with low-speed-on at 0, a frame strobe with any request collected enters the waking state for SETTLE_CYC cycles, with the oscillator enable high. The block then enters active mode. A collected timer request is issued in the first active cycle.
- R8: On such a wake with the select at 01 or 10, collected external and pin requests are issued in the first active cycle.
- R9: On such a wake with the select at 00 or 11, collected external and pin requests are issued 2^FRAME_LOG2_A cycles after the first active cycle, and not before.
- R10: In subactive mode the oscillator enable is low. A stop strobe with low-speed-on at 0 and direct-transfer-on at 1 enters the waking state, and then active mode after SETTLE_CYC cycles. A stop strobe with any other flag setting enters watch mode.
- R11: A rate-bit write takes effect in the next cycle when it is made in active mode. A write made in any other mode, including the waking state, leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle stop/standby strobe |
| lson | input | 1 | Low-speed-on flag |
| dton | input | 1 | Direct-transfer-on flag |
| frame_sel | input | 2 | Frame period select |
| ext_wake | input | 1 | Raw external interrupt request |
| tmr_ovf | input | 1 | Raw timer overflow request |
| pin_wake | input | 4 | Raw wake-pin requests |
| rate_wr | input | 1 | Write strobe for the rate bit |
| rate_din | input | 1 | New rate bit value |
| mode | output | 2 | Current mode code |
| osc_en | output | 1 | Main-oscillator enable |
| frame_strobe | output | 1 | Interrupt-frame strobe |
| irq_tmr | output | 1 | Timer interrupt request pulse |
| irq_ext | output | 1 | External interrupt request pulse |
| irq_pin | output | 4 | Wake-pin interrupt request pulses |
| rate_sel | output | 1 | Instruction-rate select bit |

## Verification
The hardest case is the long-frame wake into active mode. To reach it, the block must first be put into watch mode, a pin request must be placed after a frame strobe, and the next frame boundary must come before the settling count starts. The bench finds the frame boundaries through the `frame_strobe` port and counts cycles from there. It checks the waking code for exactly SETTLE_CYC cycles. It then checks that the pin interrupt stays low for one full long frame and rises in exactly the cycle after that frame. Subactive exits are reached by first waking from watch mode with low-speed-on set, and only then changing the flags and issuing the stop strobe.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_SUB    = 2'd1,
    MODE_WATCH  = 2'd2,
    MODE_WAKING = 2'd3
  } lpm_mode_e;

  localparam int unsigned WAKE_SRC_N = 6;  // timer, external, four pins
endpackage

// File: rtl/lpm_frame_gen.sv
module lpm_frame_gen #(
  parameter int unsigned LOG2_A = 5,
  parameter int unsigned LOG2_B = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] frame_sel,
  output logic       strobe,
  output logic       long_sel
);
  localparam int unsigned CW = (LOG2_A > LOG2_B) ? LOG2_A : LOG2_B;
  localparam logic [CW-1:0] MASK_A = CW'((64'd1 << LOG2_A) - 64'd1);
  localparam logic [CW-1:0] MASK_B = CW'((64'd1 << LOG2_B) - 64'd1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  assign long_sel = (frame_sel == 2'b00) || (frame_sel == 2'b11);
  assign mask     = long_sel ? MASK_A : MASK_B;
  assign strobe   = (cnt_q & mask) == mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);  // R5
endmodule

// File: rtl/lpm_countdown.sv
module lpm_countdown #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         abort,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic         busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign fire = busy_q && (cnt_q == '0);

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load && !abort |=> busy);  // R7
endmodule

// File: rtl/lpm_wake_pend.sv
module lpm_wake_pend #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         clr,
  output logic [N-1:0] eff
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= (pend_q[i] | req[i]) & ~clr;
    end
    assign eff[i] = pend_q[i] | req[i];

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !req[i] |=> !pend_q[i]);  // R4
  end
endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned FRAME_LOG2_A = 5,
  parameter int unsigned FRAME_LOG2_B = 3,
  parameter int unsigned SETTLE_CYC   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       lson,
  input  logic       dton,
  input  logic [1:0] frame_sel,
  input  logic       ext_wake,
  input  logic       tmr_ovf,
  input  logic [3:0] pin_wake,
  input  logic       rate_wr,
  input  logic       rate_din,
  output logic [1:0] mode,
  output logic       osc_en,
  output logic       frame_strobe,
  output logic       irq_tmr,
  output logic       irq_ext,
  output logic [3:0] irq_pin,
  output logic       rate_sel
);
  localparam int unsigned N  = WAKE_SRC_N;
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam int unsigned HW = FRAME_LOG2_A + 1;
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYC - 1);
  localparam logic [HW-1:0] HOLD_LOAD   = HW'((64'd1 << FRAME_LOG2_A) - 64'd1);

  lpm_mode_e    state_q, state_d;
  logic [N-1:0] req, eff;
  logic [N-1:0] irq_q, irq_d;
  logic [N-1:0] held_q, held_d;
  logic         rate_q;
  logic         pend_clr, long_sel;
  logic         settle_load, settle_busy, settle_fire;
  logic         hold_load, hold_abort, hold_busy, hold_fire;
  logic [N-1:1] late_src;

  assign req = {pin_wake, ext_wake, tmr_ovf};

  lpm_frame_gen #(.LOG2_A(FRAME_LOG2_A), .LOG2_B(FRAME_LOG2_B)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_sel(frame_sel),
    .strobe(frame_strobe), .long_sel(long_sel)
  );

  lpm_wake_pend #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(req), .clr(pend_clr), .eff(eff)
  );

  lpm_countdown #(.W(SW)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .abort(1'b0),
    .load_val(SETTLE_LOAD), .busy(settle_busy), .fire(settle_fire)
  );

  lpm_countdown #(.W(HW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .abort(hold_abort),
    .load_val(HOLD_LOAD), .busy(hold_busy), .fire(hold_fire)
  );

  assign late_src = held_q[N-1:1] | req[N-1:1];

  always_comb begin
    state_d     = state_q;
    irq_d       = '0;
    held_d      = held_q;
    pend_clr    = 1'b0;
    settle_load = 1'b0;
    hold_load   = 1'b0;
    hold_abort  = 1'b0;
    unique case (state_q)
      MODE_ACTIVE: begin
        pend_clr = 1'b1;
        if (hold_busy) begin
          irq_d[0] = req[0];
          if (hold_fire) begin
            irq_d[N-1:1] = late_src;
            held_d       = '0;
          end else begin
            held_d[N-1:1] = late_src;
          end
        end else begin
          irq_d = req;
        end
        if (stop_req) begin
          state_d    = MODE_WATCH;
          held_d     = '0;
          hold_abort = 1'b1;
        end
      end
      MODE_WATCH: begin
        if (frame_strobe && (|eff)) begin
          pend_clr = 1'b1;
          if (lson) begin
            state_d = MODE_SUB;
            irq_d   = eff;
          end else begin
            state_d     = MODE_WAKING;
            held_d      = eff;
            settle_load = 1'b1;
          end
        end
      end
      MODE_SUB: begin
        if (stop_req) begin
          held_d = '0;
          if (!lson && dton) begin
            state_d     = MODE_WAKING;
            settle_load = 1'b1;
          end else begin
            state_d = MODE_WATCH;
          end
        end else if (frame_strobe) begin
          irq_d    = eff;
          pend_clr = 1'b1;
        end
      end
      MODE_WAKING: begin
        pend_clr = 1'b1;
        held_d   = held_q | req;
        if (settle_fire) begin
          state_d  = MODE_ACTIVE;
          irq_d[0] = held_q[0] | req[0];
          if (long_sel && (|late_src)) begin
            hold_load = 1'b1;
            held_d    = {late_src, 1'b0};
          end else begin
            irq_d[N-1:1] = late_src;
            held_d       = '0;
          end
        end
      end
      default: state_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_ACTIVE;
      irq_q   <= '0;
      held_q  <= '0;
      rate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      held_q  <= held_d;
      if (rate_wr && (state_q == MODE_ACTIVE)) rate_q <= rate_din;
    end
  end

  assign mode     = state_q;
  assign osc_en   = (state_q == MODE_ACTIVE) || (state_q == MODE_WAKING);
  assign irq_tmr  = irq_q[0];
  assign irq_ext  = irq_q[1];
  assign irq_pin  = irq_q[5:2];
  assign rate_sel = rate_q;

  AST_QUIET_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_WATCH || state_q == MODE_SUB) && !frame_strobe |=> irq_q == '0);  // R4
  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr && state_q != MODE_ACTIVE |=> $stable(rate_q));  // R11
  AST_OSC_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> state_q == MODE_WAKING);  // R7
  AST_SUB_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MODE_SUB && stop_req |=> state_q == MODE_WATCH || state_q == MODE_WAKING);  // R10
  AST_WATCH_NO_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MODE_WATCH |=> state_q != MODE_ACTIVE);  // R7
  AST_WAKING_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MODE_WAKING |-> settle_busy);  // R7
endmodule

// File: tb/tb_lpm_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_mode_ctrl;
  localparam int TA  = 32;  // 2^FRAME_LOG2_A
  localparam int TB  = 8;   // 2^FRAME_LOG2_B
  localparam int TRC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, lson = 0, dton = 0, ext_wake = 0, tmr_ovf = 0;
  logic rate_wr = 0, rate_din = 0;
  logic [1:0] frame_sel = 2'b01;
  logic [3:0] pin_wake = '0;
  logic [1:0] mode;
  logic osc_en, frame_strobe, irq_tmr, irq_ext, rate_sel;
  logic [3:0] irq_pin;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  lpm_mode_ctrl #(.FRAME_LOG2_A(5), .FRAME_LOG2_B(3), .SETTLE_CYC(TRC)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .lson(lson), .dton(dton),
    .frame_sel(frame_sel), .ext_wake(ext_wake), .tmr_ovf(tmr_ovf),
    .pin_wake(pin_wake), .rate_wr(rate_wr), .rate_din(rate_din),
    .mode(mode), .osc_en(osc_en), .frame_strobe(frame_strobe),
    .irq_tmr(irq_tmr), .irq_ext(irq_ext), .irq_pin(irq_pin), .rate_sel(rate_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_strobe();
    int n = 0;
    while (!frame_strobe && n < 100) begin
      tick();
      n++;
    end
    if (!frame_strobe) chk("R5 strobe seen", 0, 1);
  endtask

  task automatic stop_pulse();
    stop_req = 1; tick(); stop_req = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 osc", osc_en, 1);
    chk("R1 irq", {irq_tmr, irq_ext, irq_pin}, 0);
    chk("R1 rate", rate_sel, 0);
    rst_n = 1; tick();
    chk("R1 mode after release", mode, 0);
  endtask

  task automatic t_active_pass();
    ext_wake = 1; tick(); ext_wake = 0;
    chk("R2 ext pulse", irq_ext, 1);
    chk("R2 no pin", irq_pin, 0);
    tick();
    chk("R2 ext one cycle", irq_ext, 0);
    pin_wake = 4'b0010; tick(); pin_wake = '0;
    chk("R2 pin1 pulse", irq_pin, 2);
    tick();
  endtask

  task automatic t_rate_and_watch();
    rate_wr = 1; rate_din = 1; tick(); rate_wr = 0;
    chk("R11 write in active", rate_sel, 1);
    stop_pulse();
    chk("R3 watch mode", mode, 2);
    chk("R3 osc off", osc_en, 0);
    rate_wr = 1; rate_din = 0; tick(); rate_wr = 0; tick();
    chk("R11 write ignored in watch", rate_sel, 1);
  endtask

  task automatic t_period();
    int n;
    frame_sel = 2'b01; tick(); wait_strobe(); n = 0;
    do begin tick(); n++; end while (!frame_strobe && n < 100);
    chk("R5 short period", n, TB);
    frame_sel = 2'b00; tick(); wait_strobe(); n = 0;
    do begin tick(); n++; end while (!frame_strobe && n < 100);
    chk("R5 long period", n, TA);
    chk("R5 still watch", mode, 2);
  endtask

  task automatic t_watch_to_sub();
    lson = 1; frame_sel = 2'b01;
    wait_strobe(); tick();
    pin_wake = 4'b0100; tick(); pin_wake = '0;
    chk("R4 no irq before frame", irq_pin, 0);
    chk("R4 still watch", mode, 2);
    wait_strobe();
    chk("R4 no irq on strobe cycle", irq_pin, 0);
    tick();
    chk("R6 sub mode", mode, 1);
    chk("R6 pin2 issued", irq_pin, 4);
    chk("R10 osc off in sub", osc_en, 0);
    tick();
    chk("R6 pulse ends", irq_pin, 0);
  endtask

  task automatic t_sub_frame();
    ext_wake = 1; tick(); ext_wake = 0;
    chk("R4 sub holds ext", irq_ext, 0);
    wait_strobe(); tick();
    chk("R4 sub ext on frame", irq_ext, 1);
    chk("R4 sub stays", mode, 1);
    tick();
  endtask

  task automatic t_sub_to_watch();
    lson = 0; dton = 0; stop_pulse();
    chk("R10 sub to watch", mode, 2);
  endtask

  task automatic t_wake_short();
    lson = 0; frame_sel = 2'b01;
    wait_strobe(); tick();
    tmr_ovf = 1; ext_wake = 1; tick(); tmr_ovf = 0; ext_wake = 0;
    wait_strobe(); tick();
    chk("R7 waking code", mode, 3);
    chk("R7 osc on", osc_en, 1);
    for (int i = 1; i < TRC; i++) begin
      tick();
      chk("R7 still waking", mode, 3);
      chk("R7 irq held", {irq_tmr, irq_ext}, 0);
    end
    tick();
    chk("R7 active", mode, 0);
    chk("R7 tmr issued", irq_tmr, 1);
    chk("R8 ext issued short", irq_ext, 1);
    tick();
  endtask

  task automatic t_wake_long();
    stop_pulse();
    chk("R3 watch again", mode, 2);
    lson = 0; frame_sel = 2'b00;
    wait_strobe(); tick();
    pin_wake = 4'b1000; tick(); pin_wake = '0;
    wait_strobe(); tick();
    chk("R7 waking long", mode, 3);
    repeat (TRC) tick();
    chk("R7 active long", mode, 0);
    chk("R9 pin not yet", irq_pin, 0);
    chk("R9 no tmr", irq_tmr, 0);
    for (int i = 1; i < TA; i++) begin
      tick();
      if (irq_pin != 0) chk("R9 pin early", irq_pin, 0);
    end
    tick();
    chk("R9 pin3 after frame", irq_pin, 8);
    tick();
    chk("R9 pulse ends", irq_pin, 0);
  endtask

  task automatic t_sub_to_active();
    stop_pulse();
    lson = 1; frame_sel = 2'b01;
    ext_wake = 1; tick(); ext_wake = 0;
    wait_strobe(); tick();
    chk("R6 sub again", mode, 1);
    lson = 0; dton = 1; stop_pulse();
    chk("R10 sub to waking", mode, 3);
    repeat (TRC - 1) tick();
    chk("R10 still waking", mode, 3);
    rate_wr = 1; rate_din = 0; tick(); rate_wr = 0;
    chk("R10 active", mode, 0);
    chk("R11 waking write ignored", rate_sel, 1);
    chk("R10 osc on", osc_en, 1);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_active_pass();
    t_rate_and_watch();
    t_period();
    t_watch_to_sub();
    t_sub_frame();
    t_sub_to_watch();
    t_wake_short();
    t_wake_long();
    t_sub_to_active();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule